// File: doc/BRIEF.md
# Fractional Audio Clock-Enable Divider

This block turns a parent clock-enable stream into a slower enable stream for an audio serial interface. The output rate equals the parent rate scaled by DIV / 2^ACC_W (DIV / 65536 with the default 16-bit width). Each parent enable adds DIV to a phase accumulator. Every carry out of the accumulator's top bit produces one single-cycle output enable. The output rate can therefore never exceed the parent rate, and a DIV of zero is refused.

Two parent enables arrive: one from the crystal and one from the PLL. A bypass input picks between them. Software writes a new DIV through a one-cycle write strobe. A busy flag then stays high for a fixed window, and at the end of that window the new value takes over and the accumulator restarts from zero. The output stops while the gate input is set or while fractional mode is off. In both cases the accumulator keeps its phase.

Top module: `adf_frac_audio_div`

## Requirements
- R1: After reset, tick_out and busy are 0 and the active DIV is 0, so parent enables produce no output until a valid DIV has been loaded.
- R2: Each enabled parent enable adds the active DIV to an ACC_W-bit accumulator, modulo 2^ACC_W. tick_out is high for one cycle, in the cycle after a parent enable whose addition carries out of the top bit. Starting from a cleared accumulator, N parent enables therefore give floor(N*DIV/2^ACC_W) output enables.
- R3: A write with wr_div equal to 0 is ignored. busy stays low, and the active DIV and the accumulator phase are unchanged.
- R4: A write with a non-zero wr_div sets busy in the cycle after the write. busy stays high for exactly BUSY_CYCLES cycles (default 4).
- R5: The new DIV becomes active, and the accumulator is cleared, on the clock edge that ends the busy window. Parent enables during the busy window still use the previous DIV.
- R6: While gate is 1, no output enable is produced and the accumulator holds its value.
- R7: While frac_en is 0, no output enable is produced and the accumulator holds its value.
- R8: With src_sel = 1 the crystal enable (xtal_tick) is the parent and pll_tick is ignored. With src_sel = 0 the PLL enable (pll_tick) is the parent and xtal_tick is ignored.
- R9: A valid write while busy is high restarts the busy window at its full length, and the latest written value is the one that loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | Crystal-derived parent clock enable |
| pll_tick | input | 1 | PLL-derived parent clock enable |
| src_sel | input | 1 | Bypass select: 1 picks the crystal, 0 picks the PLL |
| frac_en | input | 1 | Fractional mode enable; the output runs only when this is 1 |
| gate | input | 1 | Output gate; 1 stops the output |
| wr_en | input | 1 | One-cycle write strobe for wr_div |
| wr_div | input | ACC_W | New DIV value |
| tick_out | output | 1 | Divided clock-enable output |
| busy | output | 1 | High while a written DIV is waiting to take effect |

## Verification
An output enable is due one cycle after the rising edge that samples a carrying parent enable. busy is due one cycle after the edge that samples a write and stays high for BUSY_CYCLES cycles. The new DIV and the accumulator clear both land on the last edge of the busy window. The bench drives all inputs at falling edges and counts output enables at rising edges, which reads the value each enable held through the preceding cycle. After the last parent enable it leaves one idle cycle so that the final output enable is counted before the total is compared. With an 8-bit accumulator, the bench checks every non-zero DIV against the floor formula at a partial count and at a full period of 256 parent enables. It also measures the busy length by counting the falling edges at which busy is high.

// File: rtl/adf_pkg.sv
package adf_pkg;
    typedef enum logic {
        SRC_PLL  = 1'b0,
        SRC_XTAL = 1'b1
    } adf_src_e;
endpackage

// File: rtl/adf_src_sel.sv
module adf_src_sel
    import adf_pkg::*;
(
    input  logic xtal_tick,
    input  logic pll_tick,
    input  logic src_sel,
    output logic par_tick
);
    adf_src_e src;

    always_comb begin
        src      = adf_src_e'(src_sel);
        par_tick = (src == SRC_XTAL) ? xtal_tick : pll_tick;
    end
endmodule

// File: rtl/adf_div_loader.sv
module adf_div_loader #(
    parameter int DIV_W       = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    output logic [DIV_W-1:0] div_o,
    output logic             load_o,
    output logic             busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] pend;
        logic [DIV_W-1:0] active;
        logic [CNT_W-1:0] cnt;
    } ld_state_t;

    ld_state_t st_d, st_q;
    logic      accept_d;
    logic      load_d;

    always_comb begin
        st_d     = st_q;
        accept_d = wr_en && (wr_div != '0);
        load_d   = 1'b0;
        if (accept_d) begin
            st_d.pend = wr_div;
            st_d.cnt  = CNT_FULL;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_LAST;
            if (st_q.cnt == CNT_LAST) begin
                st_d.active = st_q.pend;
                load_d      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o  = st_q.active;
    assign load_o = load_d;
    assign busy_o = (st_q.cnt != '0);

    // R4: a valid write raises busy on the next cycle
    p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_div != '0) |=> busy_o);

    // R3: a zero write while idle leaves busy low
    p_zero_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_div == '0 && !busy_o) |=> !busy_o);

    // R5: the active value only changes as the busy window closes
    p_load_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_o) |-> $fell(busy_o));
endmodule

// File: rtl/adf_phase_acc.sv
module adf_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_tick,
    input  logic             run,
    input  logic             clear,
    input  logic [ACC_W-1:0] step,
    output logic             tick_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } ac_state_t;

    ac_state_t      st_d, st_q;
    logic [ACC_W:0] sum_d;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        sum_d     = {1'b0, st_q.acc} + {1'b0, step};
        if (clear) begin
            st_d.acc = '0;
        end else if (run && par_tick) begin
            st_d.acc  = sum_d[ACC_W-1:0];
            st_d.tick = sum_d[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R6 / R7: stopped channel gives no output on the next cycle
    p_stopped_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick_o);

    // R5: the edge that loads a new value produces no output
    p_load_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tick_o);
endmodule

// File: rtl/adf_frac_audio_div.sv
module adf_frac_audio_div #(
    parameter int ACC_W       = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_tick,
    input  logic             pll_tick,
    input  logic             src_sel,
    input  logic             frac_en,
    input  logic             gate,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_div,
    output logic             tick_out,
    output logic             busy
);
    logic             par_tick;
    logic             run;
    logic             load;
    logic [ACC_W-1:0] div_act;

    assign run = frac_en && !gate;

    adf_src_sel u_src (
        .xtal_tick (xtal_tick),
        .pll_tick  (pll_tick),
        .src_sel   (src_sel),
        .par_tick  (par_tick)
    );

    adf_div_loader #(
        .DIV_W       (ACC_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_div (wr_div),
        .div_o  (div_act),
        .load_o (load),
        .busy_o (busy)
    );

    adf_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_tick (par_tick),
        .run      (run),
        .clear    (load),
        .step     (div_act),
        .tick_o   (tick_out)
    );

    // R8: without an enable on the selected parent line there is no output
    p_parent_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_sel ? xtal_tick : pll_tick) |=> !tick_out);

    // R7: fractional mode off keeps the output low
    p_frac_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_en |=> !tick_out);
endmodule

// File: tb/adf_frac_audio_div_bench.sv
`timescale 1ns/1ps
module adf_frac_audio_div_bench;
    localparam int W   = 8;
    localparam int M   = 1 << W;
    localparam int BSY = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xtal_tick = 1'b0;
    logic         pll_tick = 1'b0;
    logic         src_sel = 1'b1;
    logic         frac_en = 1'b1;
    logic         gate = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_div = '0;
    logic         tick_out;
    logic         busy;

    int checks = 0;
    int errors = 0;
    int seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adf_frac_audio_div #(.ACC_W(W), .BUSY_CYCLES(BSY)) u_adf_frac_audio_div (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .pll_tick(pll_tick),
        .src_sel(src_sel), .frac_en(frac_en), .gate(gate), .wr_en(wr_en),
        .wr_div(wr_div), .tick_out(tick_out), .busy(busy)
    );

    always @(posedge clk) if (tick_out) seen <= seen + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_div = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int n, input bit on_xtal);
        for (int i = 0; i < n; i++) begin
            xtal_tick = on_xtal;
            pll_tick = !on_xtal;
            @(negedge clk);
        end
        xtal_tick = 1'b0;
        pll_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input int d);
        int n;
        wr(d);
        busy_len(n);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tick_out after reset", int'(tick_out), 0);
        chk("R1 busy after reset", int'(busy), 0);
        seen = 0;
        pulse(50, 1'b1);
        chk("R1 no output before load", seen, 0);

        // R2 / R4: every non-zero DIV
        for (int d = 1; d < M; d++) begin
            wr(d);
            busy_len(n);
            chk("R4 busy length", n, BSY);
            seen = 0;
            pulse(100, 1'b1);
            chk("R2 partial count", seen, (100 * d) / M);
            pulse(M - 100, 1'b1);
            chk("R2 full period count", seen, d);
        end

        // R3: zero write ignored
        load(77);
        wr(0);
        chk("R3 busy after zero write", int'(busy), 0);
        seen = 0;
        pulse(M, 1'b1);
        chk("R3 old DIV kept", seen, 77);

        // R5: accumulator cleared on load
        load(200);
        seen = 0;
        pulse(3, 1'b1);
        chk("R5 pre-reload count", seen, 2);
        load(200);
        seen = 0;
        pulse(1, 1'b1);
        chk("R5 cleared on reload", seen, 0);

        // R5: old DIV during busy window
        load(255);
        seen = 0;
        wr(1);
        pulse(2, 1'b1);
        busy_len(n);
        chk("R5 old DIV during busy", seen, 1);
        seen = 0;
        pulse(M - 1, 1'b1);
        chk("R5 new DIV short run", seen, 0);
        pulse(1, 1'b1);
        chk("R5 new DIV period", seen, 1);

        // R6: gate holds the phase
        load(128);
        seen = 0;
        pulse(1, 1'b1);
        gate = 1'b1;
        pulse(5, 1'b1);
        chk("R6 gated output", seen, 0);
        gate = 1'b0;
        pulse(1, 1'b1);
        chk("R6 phase held through gate", seen, 1);

        // R7: fractional mode off holds the phase
        load(128);
        seen = 0;
        pulse(1, 1'b1);
        frac_en = 1'b0;
        pulse(5, 1'b1);
        chk("R7 disabled output", seen, 0);
        frac_en = 1'b1;
        pulse(1, 1'b1);
        chk("R7 phase held while disabled", seen, 1);

        // R8: source select
        src_sel = 1'b1;
        load(255);
        seen = 0;
        pulse(10, 1'b0);
        chk("R8 pll ignored on crystal", seen, 0);
        pulse(10, 1'b1);
        chk("R8 crystal used", seen, 9);
        src_sel = 1'b0;
        load(255);
        seen = 0;
        pulse(10, 1'b1);
        chk("R8 crystal ignored on pll", seen, 0);
        pulse(10, 1'b0);
        chk("R8 pll used", seen, 9);
        src_sel = 1'b1;

        // R9: rewrite during busy restarts the window
        wr(10);
        @(negedge clk);
        chk("R9 busy between writes", int'(busy), 1);
        wr(20);
        busy_len(n);
        chk("R9 restarted busy length", n, BSY);
        seen = 0;
        pulse(64, 1'b1);
        chk("R9 latest value loaded", seen, 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule